// File: doc/BRIEF.md
# Paged GPIO Edge-Interrupt Controller

This block is a byte-wide register peripheral for a bank of general-purpose lines. The lines are grouped into ports of eight. Each line has a drive bit with open-drain style behaviour: a 1 turns on a pull-down and a 0 releases the line. A data-port read always returns the synchronized level of the pins, so a released line works as an input. Software reaches the block through a plain synchronous interface. A write strobe commits on the clock edge, and a read strobe returns the addressed byte combinationally in the same cycle.

The lines of the first three ports can raise interrupts. Each of these lines has three control bits: the edge it watches, whether it may interrupt, and whether it has an interrupt pending. The three sets of bits share one three-byte window. The top two bits of a page register choose which set the window reaches. The pins pass through a two-flop synchronizer and an edge detector. A pending flag is latched when the selected edge occurs on an enabled line, and it stays set until software acknowledges it. One interrupt output combines every pending flag whose line is enabled.

Top module: `paged_gpio_irq`

## Requirements
- R1: After reset the drive bits, polarity bits, enable bits and pending flags are all 0, the page register reads 0x00, `irq` is 0, and window reads in page 0 return 0x00.
- R2: A write to byte offset k, for k from 0 to 5, loads bit n of the written byte into `pull_low[8k+n]`. No other write changes `pull_low`.
- R3: A read of offset k (0 to 5) returns `pin_in[8k+7:8k]` through a two-flop synchronizer. A pin change becomes visible two clock edges after the pin changes.
- R4: Offset 7 is the page register, and a read returns the last byte written to it. Its bits 7:6 select the window at offsets 8 to 10: 1 is edge polarity, 2 is enable, 3 is pending, and 0 reads 0x00 with writes ignored. Bits 5:0 of the page register do not affect the window.
- R5: Window offsets 8, 9 and 10 address lines 0–7, 8–15 and 16–23 in every page. Bit n of the window byte is line (offset−8)·8+n.
- R6: A polarity bit of 1 selects rising edges and 0 selects falling edges. A pending flag sets only on the selected edge of its line, and only while its enable bit is 1. `irq` rises on the third clock edge after the pin changes.
- R7: In page 3, writing a 1 to a window bit clears that pending flag, and writing a 0 leaves it unchanged. A pending flag can be cleared only this way. If an enabled edge arrives on the same edge as the clear, the flag stays set.
- R8: `irq` is the OR over lines 0–23 of pending AND enable. Clearing an enable bit drops that line's contribution to `irq`, but its pending flag is kept.
- R9: Lines 24–47 never set a pending flag and never affect `irq`.
- R10: Offset 6 reads 0x00, and writes to it are ignored. Offsets 11 to 15 read 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, committed on the rising edge |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| addr | input | 4 | Byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0x00 when `rd_en` is low |
| pin_in | input | 48 | Pin levels, asynchronous |
| pull_low | output | 48 | Pull-down enables, one per line |
| irq | output | 1 | Combined interrupt request |

## Verification
Some properties are checked on every cycle:
- a pending flag can rise only when its enable bit was set on the cycle before;
- a pending flag can fall only after a page-3 acknowledge with a 1 in its bit;
- `irq` stays low while no line is enabled;
- the drive bits and the paged state stay unchanged across writes that miss them;
- page-0 window reads are zero.

Some behaviour only the bench scenarios can show:
- the exact three-edge latency from a pin change to `irq`;
- which edge each polarity value selects;
- the flag staying set when an edge and its acknowledge land on the same edge;
- the two-edge lag of data-port reads;
- the offset-to-port mapping across the three window bytes.

// File: rtl/pg_gpio_pkg.sv
package pg_gpio_pkg;
   typedef enum logic [1:0] {
      PG_NONE     = 2'd0,
      PG_POLARITY = 2'd1,
      PG_ENABLE   = 2'd2,
      PG_PENDING  = 2'd3
   } win_page_e;

   localparam int PAGE_FIELD_W = 2;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
   parameter int WIDTH  = 48,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pg_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pg_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pg_irq_port.sv
module pg_irq_port #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_s,
   input  logic         pol_we,
   input  logic         en_we,
   input  logic         ack_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] pol_q,
   output logic [W-1:0] en_q,
   output logic [W-1:0] pend_q
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise, fall, hit, set_v, clr_v;

   always_comb begin
      rise  = pin_s & ~prev_q;
      fall  = ~pin_s & prev_q;
      hit   = (pol_q & rise) | (~pol_q & fall);
      set_v = hit & en_q;
      clr_v = ack_we ? wdata : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         pol_q  <= '0;
         en_q   <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= pin_s;
         if (pol_we) pol_q <= wdata;
         if (en_we)  en_q  <= wdata;
         // a fresh edge outranks an acknowledge in the same cycle
         pend_q <= (pend_q & ~clr_v) | set_v;
      end
   end
endmodule

// File: rtl/paged_gpio_irq.sv
module paged_gpio_irq
   import pg_gpio_pkg::*;
#(
   parameter int NUM_PORTS   = 6,
   parameter int IRQ_PORTS   = 3,
   parameter int PORT_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic                        rd_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [PORT_W-1:0]           wdata,
   output logic [PORT_W-1:0]           rdata,
   input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
   output logic [NUM_PORTS*PORT_W-1:0] pull_low,
   output logic                        irq
);
   localparam int NUM_LINES = NUM_PORTS * PORT_W;
   localparam int IRQ_LINES = IRQ_PORTS * PORT_W;
   localparam int RSVD_ADDR = NUM_PORTS;
   localparam int PAGE_ADDR = NUM_PORTS + 1;
   localparam int WIN_BASE  = NUM_PORTS + 2;
   localparam int WIN_LAST  = WIN_BASE + IRQ_PORTS - 1;

   if (IRQ_PORTS < 1 || IRQ_PORTS > NUM_PORTS) begin : g_bad_irq_ports
      $error("paged_gpio_irq: IRQ_PORTS out of range");
   end
   if (PORT_W < PAGE_FIELD_W) begin : g_bad_port_w
      $error("paged_gpio_irq: PORT_W too narrow for page field");
   end
   if ((1 << ADDR_W) <= WIN_LAST) begin : g_bad_addr_w
      $error("paged_gpio_irq: ADDR_W cannot reach the window");
   end

   logic [PORT_W-1:0]    page_q;
   win_page_e            cur_page;
   logic [NUM_LINES-1:0] drive_q;
   logic [NUM_LINES-1:0] pin_s;
   logic [IRQ_LINES-1:0] pol_vec, en_vec, pend_vec;
   logic [PORT_W-1:0]    rd_mux;

   assign cur_page = win_page_e'(page_q[PORT_W-1 -: PAGE_FIELD_W]);

   // page register
   always_ff @(posedge clk) begin
      if (!rst_n)                                       page_q <= '0;
      else if (wr_en && addr == ADDR_W'(PAGE_ADDR))     page_q <= wdata;
   end

   // pin synchronizer
   pg_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   // drive registers, one byte per port
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_drive
      always_ff @(posedge clk) begin
         if (!rst_n)
            drive_q[p*PORT_W +: PORT_W] <= '0;
         else if (wr_en && addr == ADDR_W'(p))
            drive_q[p*PORT_W +: PORT_W] <= wdata;
      end
   end

   assign pull_low = drive_q;

   // interrupt-capable ports behind the paged window
   for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_irq
      logic hit_win;
      assign hit_win = wr_en && (addr == ADDR_W'(WIN_BASE + p));

      pg_irq_port #(.W(PORT_W)) u_port (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_s  (pin_s[p*PORT_W +: PORT_W]),
         .pol_we (hit_win && cur_page == PG_POLARITY),
         .en_we  (hit_win && cur_page == PG_ENABLE),
         .ack_we (hit_win && cur_page == PG_PENDING),
         .wdata  (wdata),
         .pol_q  (pol_vec[p*PORT_W +: PORT_W]),
         .en_q   (en_vec[p*PORT_W +: PORT_W]),
         .pend_q (pend_vec[p*PORT_W +: PORT_W])
      );
   end

   // read path
   always_comb begin
      rd_mux = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (addr == ADDR_W'(p)) rd_mux = pin_s[p*PORT_W +: PORT_W];
      end
      if (addr == ADDR_W'(PAGE_ADDR)) rd_mux = page_q;
      for (int p = 0; p < IRQ_PORTS; p++) begin
         if (addr == ADDR_W'(WIN_BASE + p)) begin
            case (cur_page)
               PG_POLARITY: rd_mux = pol_vec[p*PORT_W +: PORT_W];
               PG_ENABLE:   rd_mux = en_vec[p*PORT_W +: PORT_W];
               PG_PENDING:  rd_mux = pend_vec[p*PORT_W +: PORT_W];
               default:     rd_mux = '0;
            endcase
         end
      end
      rdata = rd_en ? rd_mux : '0;
   end

   assign irq = |(pend_vec & en_vec);

   // offset RSVD_ADDR decodes to nothing: reads fall through to zero
   localparam int UNUSED_RSVD = RSVD_ADDR;
endmodule

// File: rtl/pg_gpio_chk.sv
module pg_gpio_chk #(
   parameter int NUM_PORTS = 6,
   parameter int IRQ_PORTS = 3,
   parameter int PORT_W    = 8,
   parameter int ADDR_W    = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        wr_en,
   input logic                        rd_en,
   input logic [ADDR_W-1:0]           addr,
   input logic [PORT_W-1:0]           wdata,
   input logic [PORT_W-1:0]           rdata,
   input logic [NUM_PORTS*PORT_W-1:0] pull_low,
   input logic                        irq,
   input logic [PORT_W-1:0]           page_q,
   input logic [IRQ_PORTS*PORT_W-1:0] pol_vec,
   input logic [IRQ_PORTS*PORT_W-1:0] en_vec,
   input logic [IRQ_PORTS*PORT_W-1:0] pend_vec
);
   localparam int IRQ_LINES = IRQ_PORTS * PORT_W;
   localparam int RSVD_ADDR = NUM_PORTS;
   localparam int WIN_BASE  = NUM_PORTS + 2;
   localparam int WIN_LAST  = WIN_BASE + IRQ_PORTS - 1;

   for (genvar i = 0; i < IRQ_LINES; i++) begin : g_line
      // R6: a flag may rise only if its line was enabled
      p_pend_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_vec[i]) |-> $past(en_vec[i]));

      // R7: a flag may fall only after a page-3 acknowledge of its bit
      p_pend_ack_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pend_vec[i]) |-> $past(wr_en && page_q[PORT_W-1 -: 2] == 2'b11
                                      && addr == ADDR_W'(WIN_BASE + i / PORT_W)
                                      && wdata[i % PORT_W]));
   end

   // R8: no enabled line, no interrupt
   p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_vec == '0) |-> !irq);

   // R2: drive bits hold unless a data offset is written
   p_drive_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr < ADDR_W'(NUM_PORTS)) |=> $stable(pull_low));

   // R10: a write to the reserved offset touches no state
   p_rsvd_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(RSVD_ADDR)) |=>
         ($stable(page_q) && $stable(en_vec) && $stable(pol_vec) && $stable(pull_low)));

   // R4: page 0 window reads are zero
   p_page0_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && page_q[PORT_W-1 -: 2] == 2'b00
       && addr >= ADDR_W'(WIN_BASE) && addr <= ADDR_W'(WIN_LAST)) |-> (rdata == '0));
endmodule

bind paged_gpio_irq pg_gpio_chk #(
   .NUM_PORTS (NUM_PORTS),
   .IRQ_PORTS (IRQ_PORTS),
   .PORT_W    (PORT_W),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .pull_low (pull_low),
   .irq      (irq),
   .page_q   (page_q),
   .pol_vec  (pol_vec),
   .en_vec   (en_vec),
   .pend_vec (pend_vec)
);

// File: tb/test_paged_gpio_irq.sv
`timescale 1ns/1ps
module test_paged_gpio_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [47:0] ext = '1;
   logic [47:0] pin_in;
   logic [47:0] pull_low;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [7:0] exp_q [$];
   string      req_q [$];

   always #2 clk = ~clk;

   assign pin_in = ext & ~pull_low;

   paged_gpio_irq i_paged_gpio_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .pin_in   (pin_in),
      .pull_low (pull_low),
      .irq      (irq)
   );

   // monitor: compares each read against the scoreboard
   always @(negedge clk) begin
      if (rd_en) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL scoreboard empty requirement=none actual=%h expected=none", rdata);
         end else begin
            logic [7:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            if (rdata !== e) begin
               bad++;
               $display("FAIL %s read addr=%0d actual=%h expected=%h", r, addr, rdata, e);
            end
         end
      end
   end

   task automatic chk(input logic [47:0] act, input logic [47:0] exp, input string req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
      @(posedge clk); #1;
      exp_q.push_back(e);
      req_q.push_back(req);
      rd_en = 1'b1; addr = a;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic pin(input int line, input logic v);
      @(posedge clk); #1;
      ext[line] = v;
      settle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(irq, 0, "R1");
      chk(pull_low, 0, "R1");
      rst_n = 1'b1;
      settle();
      rd(4'd7, 8'h00, "R1");
      rd(4'd8, 8'h00, "R1");
      rd(4'd10, 8'h00, "R1");

      // data ports: drive and live readback
      wr(4'd2, 8'hA5);
      chk(pull_low, 48'hA5 << 16, "R2");
      settle();
      rd(4'd2, 8'h5A, "R3");
      rd(4'd0, 8'hFF, "R3");
      rd(4'd5, 8'hFF, "R3");
      wr(4'd2, 8'h00);
      settle();
      rd(4'd2, 8'hFF, "R3");
      wr(4'd0, 8'h01);
      rd(4'd0, 8'hFF, "R3");   // one edge after the write: still old level
      rd(4'd0, 8'hFE, "R3");   // synchronizer has caught up
      wr(4'd0, 8'h00);
      settle();

      // reserved and unmapped offsets
      wr(4'd6, 8'hFF);
      chk(pull_low, 0, "R10");
      rd(4'd6, 8'h00, "R10");
      rd(4'd7, 8'h00, "R10");
      wr(4'd15, 8'hFF);
      chk(pull_low, 0, "R10");
      rd(4'd12, 8'h00, "R10");

      // page selection and window mapping
      wr(4'd7, 8'h40);
      rd(4'd7, 8'h40, "R4");
      wr(4'd9, 8'h01);                 // line 8 rising, line 9 falling
      wr(4'd7, 8'h80);
      wr(4'd9, 8'h03);                 // enable lines 8 and 9
      rd(4'd9, 8'h03, "R4");
      rd(4'd8, 8'h00, "R5");
      wr(4'd7, 8'h40);
      rd(4'd9, 8'h01, "R4");
      rd(4'd8, 8'h00, "R5");
      wr(4'd7, 8'hC0);
      rd(4'd9, 8'h00, "R6");
      chk(irq, 0, "R6");

      // wrong edge on a rising line
      pin(8, 1'b0);
      rd(4'd9, 8'h00, "R6");
      chk(irq, 0, "R6");

      // rising edge with exact latency
      @(posedge clk); #1;
      ext[8] = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      chk(irq, 0, "R6");
      @(posedge clk); #1;
      chk(irq, 1, "R6");
      rd(4'd9, 8'h01, "R6");

      // falling line, and a line that is not enabled
      pin(9, 1'b0);
      rd(4'd9, 8'h03, "R6");
      pin(10, 1'b0);
      pin(10, 1'b1);
      rd(4'd9, 8'h03, "R6");

      // acknowledge
      wr(4'd9, 8'h02);
      rd(4'd9, 8'h01, "R7");
      wr(4'd9, 8'h00);
      rd(4'd9, 8'h01, "R7");
      chk(irq, 1, "R7");
      wr(4'd9, 8'h01);
      rd(4'd9, 8'h00, "R7");
      chk(irq, 0, "R7");

      // edge and acknowledge on the same edge
      pin(8, 1'b0);
      @(posedge clk); #1;
      ext[8] = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      wr_en = 1'b1; addr = 4'd9; wdata = 8'h01;
      @(posedge clk); #1;
      wr_en = 1'b0;
      rd(4'd9, 8'h01, "R7");
      wr(4'd9, 8'h01);
      rd(4'd9, 8'h00, "R7");

      // enable gating of irq
      pin(9, 1'b1);
      pin(9, 1'b0);
      chk(irq, 1, "R8");
      wr(4'd7, 8'h80);
      wr(4'd9, 8'h01);
      chk(irq, 0, "R8");
      wr(4'd7, 8'hC0);
      rd(4'd9, 8'h02, "R8");
      wr(4'd7, 8'h80);
      wr(4'd9, 8'h03);
      chk(irq, 1, "R8");
      wr(4'd7, 8'hC0);
      wr(4'd9, 8'h02);
      chk(irq, 0, "R8");

      // third window byte reaches port 2
      wr(4'd7, 8'h40);
      wr(4'd10, 8'h80);
      wr(4'd7, 8'h80);
      wr(4'd10, 8'h80);
      wr(4'd7, 8'hC0);
      pin(23, 1'b0);
      rd(4'd10, 8'h00, "R5");
      pin(23, 1'b1);
      rd(4'd10, 8'h80, "R5");
      rd(4'd8, 8'h00, "R5");
      rd(4'd9, 8'h00, "R5");
      chk(irq, 1, "R5");
      wr(4'd10, 8'h80);
      rd(4'd10, 8'h00, "R5");
      chk(irq, 0, "R5");

      // upper lines never interrupt
      pin(30, 1'b0);
      pin(30, 1'b1);
      pin(47, 1'b0);
      pin(47, 1'b1);
      chk(irq, 0, "R9");
      rd(4'd8, 8'h00, "R9");
      rd(4'd9, 8'h00, "R9");
      rd(4'd10, 8'h00, "R9");

      // page 0 ignores writes; low page bits do not matter
      wr(4'd7, 8'h00);
      wr(4'd9, 8'hFF);
      rd(4'd9, 8'h00, "R4");
      wr(4'd7, 8'h8F);
      rd(4'd7, 8'h8F, "R4");
      rd(4'd9, 8'h03, "R4");

      repeat (2) @(posedge clk);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL scoreboard leftover requirement=none actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog requirement=none actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule